// File: doc/BRIEF.md
# Power-Controller Register Access Engine

This block executes register-access messages on the controller side of a host mailbox. A message arrives as an opcode, a sub-command, a byte count and a packed payload of up to sixteen bytes. The engine validates the whole message, unpacks the 16-bit register addresses and the data bytes, and performs a write, a read or a masked read-modify-write on a local file of 8-bit registers. Read results go to a response buffer. It then pulses `done` with `err` telling whether the message was refused.

Validation is completed before any register is touched. A message with a wrong opcode, an unknown sub-command, a byte count that does not match its sub-command's layout, or any address outside the implemented register file changes nothing. A valid message is carried out one register per clock, in the order of its address list.

Top module: `pcr_access_engine`

## Requirements
- R1: After reset `busy`, `done` and `err` are low, every response-buffer byte is zero and every register of the file reads back as zero.
- R2: Only opcode 0xFF is executed; any other opcode ends with `err` high and no register changed.
- R3: Sub-command 0 writes N registers. The payload holds N addresses of 16 bits, address k at bytes 2k (low) and 2k+1 (high), then N data bytes starting at byte 2N; the size is 3N. Writes happen in list order, so a repeated address keeps the last data byte.
- R4: Sub-command 1 reads N registers. The payload holds the N address pairs only (size 2N), and the value of the register at address k lands in response byte k (`rdBuf` bits 8k+7..8k).
- R5: Sub-command 2 reads, merges and writes back one register. The payload is address low, address high, value, mask (size 4), and the new contents are (old AND NOT mask) OR (value AND mask), written in the cycle after the read.
- R6: N must lie between 1 and 5. Sub-commands other than 0, 1 and 2 are refused with `err` high.
- R7: A size that does not fit the sub-command's layout, including sizes that imply more than 5 registers, ends with `err` high and no register changed.
- R8: If any listed address is at or above the register-file depth (32 by default), the whole message is refused with `err` high, including accesses to valid addresses earlier in the list.
- R9: `done` is a one-cycle pulse. Counting the clock edge that samples `start` as edge 0, `done` is high after edge N+1 for reads and writes, after edge 3 for read-modify-write, and after edge 1 for refused messages. `busy` is high from edge 0 until `done` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Message strobe, sampled while idle |
| opcode | input | 8 | Message opcode |
| subCmd | input | 4 | Sub-command: 0 write, 1 read, 2 read-modify-write |
| size | input | 8 | Payload byte count |
| payload | input | 128 | Payload bytes, byte k at bits 8k+7..8k |
| busy | output | 1 | Engine is handling a message |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last message was refused; valid with `done` |
| rdBuf | output | 40 | Response bytes, byte k at bits 8k+7..8k |

## Verification
The bench goes after the cases where refusal must be total: a bad address at the end of a write list, sizes one byte off and sizes for six registers. A design that committed writes while it scanned the list would leave the earlier registers changed, and later reads expose that. A repeated address in one write list shows whether list order is kept; a design that wrote in parallel or in reverse keeps the wrong byte. Read-modify-write is checked with partial, all-zero and all-one masks, which catches an inverted mask or a merge that uses stale data. Exact `done` latencies for each message kind catch skipped or extra access cycles.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int MAX_REGS  = 5;
  localparam int PAY_BYTES = 16;
  localparam int CNT_W     = $clog2(MAX_REGS + 1);
  localparam int PB_W      = $clog2(PAY_BYTES);

  localparam logic [7:0] OPC_REGACC = 8'hFF;
  localparam logic [3:0] SUB_WRITE  = 4'd0;
  localparam logic [3:0] SUB_READ   = 4'd1;
  localparam logic [3:0] SUB_MERGE  = 4'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             wrEn;
    logic             rdEn;
    logic             mergeRd;
    logic             mergeWr;
    logic [CNT_W-1:0] idx;
  } pcr_strobe_t;
endpackage

// File: rtl/pcr_datapath.sv
module pcr_datapath
  import pcr_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pcr_strobe_t             strb,
  input  logic [7:0]              opcode,
  input  logic [3:0]              subCmd,
  input  logic [7:0]              size,
  input  logic [PAY_BYTES*8-1:0]  payload,
  output logic                    msgOk,
  output logic                    isMerge,
  output logic                    isRead,
  output logic [CNT_W-1:0]        cnt,
  output logic [MAX_REGS*8-1:0]   rdBuf
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]  opcR;
  logic [3:0]  subR;
  logic [7:0]  sizeR;
  logic [7:0]  payR     [PAY_BYTES];
  logic [7:0]  regFile  [DEPTH];
  logic [7:0]  rdBufR   [MAX_REGS];
  logic [7:0]  oldR;
  logic [15:0] addrList [MAX_REGS];
  logic [7:0]  dataList [MAX_REGS];
  logic        sizeOk;
  logic        addrOk;

  // unpack the address pairs and the data bytes behind them
  always_comb begin
    for (int k = 0; k < MAX_REGS; k++) begin
      int off;
      addrList[k] = {payR[PB_W'(2*k+1)], payR[PB_W'(2*k)]};
      off = 2 * int'(cnt) + k;
      dataList[k] = (off < PAY_BYTES) ? payR[PB_W'(off)] : 8'h00;
    end
  end

  // derive register count from the sub-command's layout
  always_comb begin
    cnt    = '0;
    sizeOk = 1'b0;
    for (int n = 1; n <= MAX_REGS; n++) begin
      if (subR == SUB_WRITE && sizeR == 8'(3*n)) begin
        cnt = CNT_W'(n); sizeOk = 1'b1;
      end
      if (subR == SUB_READ && sizeR == 8'(2*n)) begin
        cnt = CNT_W'(n); sizeOk = 1'b1;
      end
    end
    if (subR == SUB_MERGE && sizeR == 8'd4) begin
      cnt = CNT_W'(1); sizeOk = 1'b1;
    end
  end

  always_comb begin
    addrOk = 1'b1;
    for (int k = 0; k < MAX_REGS; k++)
      if (CNT_W'(k) < cnt && {16'h0, addrList[k]} >= 32'(DEPTH)) addrOk = 1'b0;
  end

  assign msgOk   = (opcR == OPC_REGACC) && sizeOk && addrOk;
  assign isMerge = (subR == SUB_MERGE);
  assign isRead  = (subR == SUB_READ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcR  <= '0;
      subR  <= '0;
      sizeR <= '0;
      for (int k = 0; k < PAY_BYTES; k++) payR[k] <= '0;
    end else if (strb.load) begin
      opcR  <= opcode;
      subR  <= subCmd;
      sizeR <= size;
      for (int k = 0; k < PAY_BYTES; k++) payR[k] <= payload[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) regFile[k] <= '0;
    end else if (strb.wrEn) begin
      regFile[addrList[strb.idx][AW-1:0]] <= dataList[strb.idx];
    end else if (strb.mergeWr) begin
      regFile[addrList[0][AW-1:0]] <= (oldR & ~dataList[1]) | (dataList[0] & dataList[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oldR <= '0;
      for (int k = 0; k < MAX_REGS; k++) rdBufR[k] <= '0;
    end else begin
      if (strb.rdEn)    rdBufR[strb.idx] <= regFile[addrList[strb.idx][AW-1:0]];
      if (strb.mergeRd) oldR <= regFile[addrList[0][AW-1:0]];
    end
  end

  for (genvar g = 0; g < MAX_REGS; g++) begin : gResp
    assign rdBuf[8*g +: 8] = rdBufR[g];
  end
endmodule

// File: rtl/pcr_control.sv
module pcr_control
  import pcr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             msgOk,
  input  logic             isMerge,
  input  logic             isRead,
  input  logic [CNT_W-1:0] cnt,
  output pcr_strobe_t      strb,
  output logic             busy,
  output logic             done,
  output logic             err
);
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_ACCESS, ST_MERGE, ST_FIN} state_t;

  state_t           state, nxt;
  logic [CNT_W-1:0] idxR;
  logic             errR;

  always_comb begin
    strb     = '0;
    strb.idx = idxR;
    nxt      = state;
    case (state)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        nxt       = ST_CHECK;
      end
      ST_CHECK: nxt = msgOk ? ST_ACCESS : ST_FIN;
      ST_ACCESS: begin
        if (isMerge) begin
          strb.mergeRd = 1'b1;
          nxt          = ST_MERGE;
        end else begin
          if (isRead) strb.rdEn = 1'b1;
          else        strb.wrEn = 1'b1;
          if (idxR == cnt - CNT_W'(1)) nxt = ST_FIN;
        end
      end
      ST_MERGE: begin
        strb.mergeWr = 1'b1;
        nxt          = ST_FIN;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idxR  <= '0;
      errR  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_CHECK)  idxR <= '0;
      if (state == ST_ACCESS) idxR <= idxR + CNT_W'(1);
      if (strb.load) errR <= 1'b0;
      else if (state == ST_CHECK && !msgOk) errR <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
  assign err  = errR;
endmodule

// File: rtl/pcr_access_engine.sv
module pcr_access_engine
  import pcr_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [7:0]             opcode,
  input  logic [3:0]             subCmd,
  input  logic [7:0]             size,
  input  logic [PAY_BYTES*8-1:0] payload,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [MAX_REGS*8-1:0]  rdBuf
);
  pcr_strobe_t      strb;
  logic             msgOk;
  logic             isMerge;
  logic             isRead;
  logic [CNT_W-1:0] cnt;

  pcr_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .msgOk(msgOk), .isMerge(isMerge),
    .isRead(isRead), .cnt(cnt), .strb(strb), .busy(busy), .done(done), .err(err)
  );

  pcr_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opcode(opcode), .subCmd(subCmd),
    .size(size), .payload(payload), .msgOk(msgOk), .isMerge(isMerge),
    .isRead(isRead), .cnt(cnt), .rdBuf(rdBuf)
  );
endmodule

// File: rtl/pcr_access_chk.sv
module pcr_access_chk
  import pcr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [7:0]  opcode,
  input logic [3:0]  subCmd,
  input logic [7:0]  size,
  input pcr_strobe_t strb
);
  logic       opcOkL;
  logic [3:0] subL;
  logic [7:0] sizeL;
  logic       wroteSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcOkL    <= 1'b0;
      subL      <= '0;
      sizeL     <= '0;
      wroteSeen <= 1'b0;
    end else if (start && !busy) begin
      opcOkL    <= (opcode == OPC_REGACC);
      subL      <= subCmd;
      sizeL     <= size;
      wroteSeen <= 1'b0;
    end else if (strb.wrEn || strb.mergeWr) begin
      wroteSeen <= 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> busy); // R9
  AST_START_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> busy); // R9
  AST_REFUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) (done && err) |-> !wroteSeen); // R7
  AST_BAD_OPCODE_ERR: assert property (@(posedge clk) disable iff (!rstN) (done && !opcOkL) |-> err); // R2
  AST_BAD_SUB_ERR: assert property (@(posedge clk) disable iff (!rstN) (done && subL > SUB_MERGE) |-> err); // R6
  AST_READ_SIZE_EVEN: assert property (@(posedge clk) disable iff (!rstN) (done && !err && subL == SUB_READ) |-> !sizeL[0]); // R4
  AST_MERGE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN) strb.mergeWr |-> $past(strb.mergeRd)); // R5
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN) $onehot0({strb.wrEn, strb.rdEn, strb.mergeRd, strb.mergeWr})); // R3
endmodule

bind pcr_access_engine pcr_access_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .err(err),
  .opcode(opcode), .subCmd(subCmd), .size(size), .strb(strb)
);

// File: tb/sim_pcr_access_engine.sv
module sim_pcr_access_engine;
  import pcr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   start = 1'b0;
  logic [7:0]             opcode = '0;
  logic [3:0]             subCmd = '0;
  logic [7:0]             size = '0;
  logic [PAY_BYTES*8-1:0] payload = '0;
  logic                   busy, done, err;
  logic [MAX_REGS*8-1:0]  rdBuf;

  pcr_access_engine #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .subCmd(subCmd),
    .size(size), .payload(payload), .busy(busy), .done(done), .err(err), .rdBuf(rdBuf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        expErr;
    logic [7:0]  expLat;
    logic [3:0]  nRd;
    logic [39:0] expRd;
    logic [7:0]  req;
  } exp_t;

  exp_t       scoreQ[$];
  logic [7:0] model [DEPTH];
  int         checks = 0;
  int         fails = 0;
  int         lat = 0;
  bit         inFlight = 0;
  bit         ended = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver: compute expectation from the requirements, push, then issue
  task automatic sendMsg(input logic [7:0] opc, input logic [3:0] sub, input logic [7:0] sz,
                         input logic [127:0] pay, input logic [7:0] req);
    exp_t e;
    int   n = 0;
    bit   ok = 1;
    e = '0;
    e.req = req;
    if (sub == 4'd0 && sz % 3 == 0) n = sz / 3;
    else if (sub == 4'd1 && sz % 2 == 0) n = sz / 2;
    else if (sub == 4'd2 && sz == 8'd4) n = 1;
    if (n < 1 || n > MAX_REGS || opc != 8'hFF) ok = 0;
    for (int k = 0; k < n && k < MAX_REGS; k++)
      if (int'(pay[16*k +: 16]) >= DEPTH) ok = 0;
    if (ok) begin
      if (sub == 4'd0) begin
        for (int k = 0; k < n; k++) model[int'(pay[16*k +: 16])] = pay[8*(2*n+k) +: 8];
      end else if (sub == 4'd1) begin
        e.nRd = 4'(n);
        for (int k = 0; k < n; k++) e.expRd[8*k +: 8] = model[int'(pay[16*k +: 16])];
      end else begin
        int a = int'(pay[15:0]);
        model[a] = (model[a] & ~pay[31:24]) | (pay[23:16] & pay[31:24]);
      end
    end
    e.expErr = !ok;
    e.expLat = !ok ? 8'd2 : (sub == 4'd2) ? 8'd4 : 8'(n + 2);
    scoreQ.push_back(e);
    @(negedge clk);
    opcode = opc; subCmd = sub; size = sz; payload = pay;
    start = 1'b1; lat = 0; inFlight = 1;
    @(negedge clk);
    start = 1'b0;
    wait (!inFlight);
    @(negedge clk);
  endtask

  task automatic wrRegs(input int n, input logic [79:0] addrs, input logic [39:0] data, input logic [7:0] req);
    logic [127:0] p = '0;
    for (int k = 0; k < n; k++) begin
      p[16*k +: 16]      = addrs[16*k +: 16];
      p[8*(2*n+k) +: 8]  = data[8*k +: 8];
    end
    sendMsg(8'hFF, 4'd0, 8'(3*n), p, req);
  endtask

  task automatic rdRegs(input int n, input logic [79:0] addrs, input logic [7:0] req);
    logic [127:0] p = '0;
    for (int k = 0; k < n; k++) p[16*k +: 16] = addrs[16*k +: 16];
    sendMsg(8'hFF, 4'd1, 8'(2*n), p, req);
  endtask

  task automatic mergeReg(input logic [15:0] a, input logic [7:0] v, input logic [7:0] m, input logic [7:0] req);
    sendMsg(8'hFF, 4'd2, 8'd4, {96'h0, m, v, a}, req);
  endtask

  // monitor: pop and compare when done is seen
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (inFlight) begin
        lat++;
        if (done) begin
          e = scoreQ.pop_front();
          chk($sformatf("R%0d", e.req), 64'(err), 64'(e.expErr), "err flag");
          chk("R9", 64'(lat), 64'(e.expLat), "done latency");
          for (int k = 0; k < int'(e.nRd); k++)
            chk("R4", 64'(rdBuf[8*k +: 8]), 64'(e.expRd[8*k +: 8]), $sformatf("response byte %0d", k));
          inFlight = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 64'(busy), 64'd0, "busy after reset");
    chk("R1", 64'(done), 64'd0, "done after reset");
    chk("R1", 64'(err),  64'd0, "err after reset");
    chk("R1", 64'(rdBuf), 64'd0, "response after reset");
    rdRegs(3, {16'd0, 16'd0, 16'd31, 16'd1, 16'd0}, 8'd1);              // R1 file cleared
    wrRegs(5, {16'd12, 16'd0, 16'd31, 16'd7, 16'd3},
           {8'hE5, 8'hD4, 8'hC3, 8'hB2, 8'hA1}, 8'd3);                    // R3, R6 max count
    rdRegs(5, {16'd3, 16'd12, 16'd7, 16'd0, 16'd31}, 8'd4);             // R4 scrambled order
    wrRegs(2, {48'h0, 16'd4, 16'd4}, {24'h0, 8'h22, 8'h11}, 8'd3);      // R3 last duplicate wins
    rdRegs(1, {64'h0, 16'd4}, 8'd3);
    mergeReg(16'd3, 8'hF0, 8'h3C, 8'd5);                                // R5 partial mask
    mergeReg(16'd7, 8'h5A, 8'h00, 8'd5);                                // R5 mask none
    mergeReg(16'd31, 8'h5A, 8'hFF, 8'd5);                               // R5 mask all
    rdRegs(3, {32'h0, 16'd31, 16'd7, 16'd3}, 8'd5);
    sendMsg(8'hFE, 4'd0, 8'd3, {104'h0, 8'h77, 16'd5}, 8'd2);           // R2 wrong opcode
    sendMsg(8'hFF, 4'd3, 8'd3, {104'h0, 8'h77, 16'd5}, 8'd6);           // R6 unknown sub
    sendMsg(8'hFF, 4'd0, 8'd4, {104'h0, 8'h77, 16'd5}, 8'd7);           // R7 size off by one
    sendMsg(8'hFF, 4'd0, 8'd18, {128{1'b0}}, 8'd7);                     // R7 six registers
    sendMsg(8'hFF, 4'd0, 8'd0, {128{1'b0}}, 8'd6);                      // R6 zero registers
    sendMsg(8'hFF, 4'd1, 8'd5, {128{1'b0}}, 8'd7);                      // R7 odd read size
    sendMsg(8'hFF, 4'd2, 8'd3, {104'h0, 8'h77, 16'd5}, 8'd7);           // R7 short merge
    wrRegs(2, {48'h0, 16'd40, 16'd6}, {24'h0, 8'h99, 8'h88}, 8'd8);     // R8 late bad address
    wrRegs(1, {64'h0, 16'h0105}, {32'h0, 8'h66}, 8'd8);                 // R8 high byte set
    mergeReg(16'd32, 8'hFF, 8'hFF, 8'd8);                               // R8 merge past end
    rdRegs(3, {32'h0, 16'd6, 16'd5, 16'd5}, 8'd7);                      // R7 R8 nothing changed
    rdRegs(2, {48'h0, 16'd33, 16'd1}, 8'd8);                            // R8 read refused
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule